// File: doc/BRIEF.md
# Post-Scaler and Load Clock Divider

This block turns a fast timebase into two synchronous clock waveforms for a video output path. A post-scaler picks one of three rates: the undivided rate, half that rate or a quarter of it. It can also hand both outputs over to static levels for board test. The post-scaled pixel clock then drives a load divider. That divider produces a load clock at one of six fixed ratios, and the duty cycle is exactly 50% for odd ratios as well as even ones.

The input `clk` is the sampling timebase. At the undivided rate, one cycle of `clk` is one half-period of the pixel clock. Both outputs are registered, so every edge is aligned to `clk`. The load divider counts edges of the post-scaled clock. Each phase of the load clock therefore spans a whole number of `clk` cycles, for any ratio.

Changes to the select code and to the ratio code are applied only at safe boundaries. This keeps the outputs free of shortened pulses.

Top module: `postscale_loaddiv`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pix_o` and `load_o` are 0. Reset selects the undivided rate and a load ratio of 4, and the load clock starts in its low phase.
- R2: Select code 00 gives a `pix_o` period of 2 `clk` cycles, code 01 a period of 4 cycles and code 10 a period of 8 cycles. Each period is high for half its length.
- R3: Select code 11 is test mode. One cycle after any input change, `pix_o` equals `aux_i` and `load_o` equals `tst_load_i`. The load divider holds its count while test mode is active.
- R4: Ratio codes 0, 1, 2, 3, 4 and 5 select load ratios 3, 4, 5, 6, 8 and 10. Codes 6 and 7 select ratio 4. The load period is the ratio times the `pix_o` period.
- R5: Outside test mode and suppression, `load_o` is high for exactly ratio × half pixel period `clk` cycles and low for the same number, including odd ratios. Every `load_o` edge coincides with a `pix_o` edge.
- R6: A new ratio code is taken only on the cycle in which `load_o` starts a high phase. The high and low phases already in progress keep the old ratio.
- R7: `sel_i` is sampled once every 8 `clk` cycles. Counting the first cycle after reset as cycle 0, sampling happens on cycles 7, 15, 23 and so on, and the new selection acts from the following cycle.
- R8: Outside test mode, `sup_i` high forces `load_o` low one cycle later. The divider keeps counting, so when `sup_i` drops the load clock resumes with its original phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase, one cycle per half-period of the undivided pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Post-scaler select: 00 undivided, 01 half, 10 quarter, 11 test |
| mod_i | input | 3 | Load ratio code |
| aux_i | input | 1 | Static pixel clock level in test mode |
| sup_i | input | 1 | Holds the load clock low |
| tst_load_i | input | 1 | Static load clock level in test mode |
| pix_o | output | 1 | Post-scaled pixel clock |
| load_o | output | 1 | Load clock |

## Verification
A wrong divider count shows at `load_o` as a phase that is too long or too short. It becomes visible within one load period, which is at most 80 `clk` cycles at ratio 10 and quarter rate. A corrupted select latch or timebase changes the `pix_o` period within 8 cycles. A ratio code taken at the wrong moment shortens the high phase that is running when the code changes. The bench compares both outputs against a behavioural model on every cycle, and it also measures phase lengths directly for every ratio code and every rate.

// File: rtl/postscale_loaddiv_pkg.sv
package postscale_loaddiv_pkg;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_TEST = 2'b11;

  // ratio code to divider length (codes beyond the six defined ones fall back to 4)
  function automatic logic [3:0] ratio_of(input logic [2:0] code);
    logic [3:0] r;
    case (code)
      3'd0:    r = 4'd3;
      3'd1:    r = 4'd4;
      3'd2:    r = 4'd5;
      3'd3:    r = 4'd6;
      3'd4:    r = 4'd8;
      3'd5:    r = 4'd10;
      default: r = 4'd4;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/postscale_timebase.sv
module postscale_timebase
  import postscale_loaddiv_pkg::*;
#(
  parameter int PH_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  output logic [PH_W-1:0]  ph_o,
  output logic [SEL_W-1:0] sel_q_o,
  output logic             lvl_o,
  output logic             tick_o
);

  localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

  logic [PH_W-1:0]  ph_q;
  logic [SEL_W-1:0] sel_q;
  logic             pl_q;
  logic [PH_W:0]    stage_v;
  logic             lvl;

  // one bit of the timebase per post-scaler rate, plus a filler slot for test code
  genvar g;
  generate
    for (g = 0; g < PH_W; g++) begin : g_stage
      assign stage_v[g] = ph_q[g];
    end
  endgenerate
  assign stage_v[PH_W] = 1'b0;

  always_comb begin
    if (sel_q == SEL_TEST) lvl = pl_q;
    else                   lvl = stage_v[sel_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      sel_q <= '0;
      pl_q  <= 1'b0;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (ph_q == PH_LAST) sel_q <= sel_i;
      pl_q <= lvl;
    end
  end

  assign ph_o    = ph_q;
  assign sel_q_o = sel_q;
  assign lvl_o   = lvl;
  assign tick_o  = (lvl != pl_q);

endmodule

// File: rtl/postscale_ldiv.sv
module postscale_ldiv
  import postscale_loaddiv_pkg::*;
#(
  parameter int          CNT_W  = 4,
  parameter int          CODE_W = 3,
  parameter logic [2:0]  RST_CODE = 3'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] mod_i,
  output logic              ld_next_o,
  output logic              ld_q_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  ratio_o,
  output logic [CODE_W-1:0] code_o
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              ld_q;
  logic [CNT_W-1:0]  ratio;
  logic              wrap;

  assign ratio = CNT_W'(ratio_of(3'(code_q)));
  assign wrap  = tick_i && (cnt_q == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ld_q   <= 1'b0;
      code_q <= CODE_W'(RST_CODE);
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        ld_q  <= ~ld_q;
        if (!ld_q) code_q <= mod_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ld_next_o = wrap ? ~ld_q : ld_q;
  assign ld_q_o    = ld_q;
  assign cnt_o     = cnt_q;
  assign ratio_o   = ratio;
  assign code_o    = code_q;

endmodule

// File: rtl/postscale_outreg.sv
module postscale_outreg
  import postscale_loaddiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_q_i,
  input  logic             lvl_i,
  input  logic             ld_next_i,
  input  logic             aux_i,
  input  logic             sup_i,
  input  logic             tst_load_i,
  output logic             pix_o,
  output logic             load_o
);

  logic test_on;
  assign test_on = (sel_q_i == SEL_TEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o  <= 1'b0;
      load_o <= 1'b0;
    end else begin
      pix_o  <= test_on ? aux_i : lvl_i;
      load_o <= test_on ? tst_load_i : (sup_i ? 1'b0 : ld_next_i);
    end
  end

endmodule

// File: rtl/postscale_loaddiv.sv
module postscale_loaddiv
  import postscale_loaddiv_pkg::*;
#(
  parameter int         PH_W     = 3,
  parameter int         CNT_W    = 4,
  parameter int         CODE_W   = 3,
  parameter logic [2:0] RST_CODE = 3'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CODE_W-1:0] mod_i,
  input  logic              aux_i,
  input  logic              sup_i,
  input  logic              tst_load_i,
  output logic              pix_o,
  output logic              load_o
);

  logic [PH_W-1:0]   ph_w;
  logic [SEL_W-1:0]  sel_q_w;
  logic              lvl_w;
  logic              tick_w;
  logic              ld_next_w;
  logic              ld_q_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  ratio_w;
  logic [CODE_W-1:0] code_w;

  postscale_timebase #(.PH_W(PH_W)) u_tb (
    .clk(clk), .rst(rst), .sel_i(sel_i),
    .ph_o(ph_w), .sel_q_o(sel_q_w), .lvl_o(lvl_w), .tick_o(tick_w)
  );

  postscale_ldiv #(.CNT_W(CNT_W), .CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_div (
    .clk(clk), .rst(rst), .tick_i(tick_w), .mod_i(mod_i),
    .ld_next_o(ld_next_w), .ld_q_o(ld_q_w), .cnt_o(cnt_w),
    .ratio_o(ratio_w), .code_o(code_w)
  );

  postscale_outreg u_out (
    .clk(clk), .rst(rst), .sel_q_i(sel_q_w), .lvl_i(lvl_w),
    .ld_next_i(ld_next_w), .aux_i(aux_i), .sup_i(sup_i),
    .tst_load_i(tst_load_i), .pix_o(pix_o), .load_o(load_o)
  );

endmodule

// File: rtl/postscale_loaddiv_chk.sv
module postscale_loaddiv_chk #(
  parameter int PH_W   = 3,
  parameter int CNT_W  = 4,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        sel_q,
  input logic [PH_W-1:0]   ph,
  input logic              pix_o,
  input logic              load_o,
  input logic              aux_i,
  input logic              sup_i,
  input logic              tst_load_i,
  input logic              ld_q,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ratio,
  input logic [CODE_W-1:0] code
);

  logic [1:0] up;
  always_ff @(posedge clk) begin
    if (rst) up <= '0;
    else if (up != 2'd3) up <= up + 1'b1;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (!pix_o && !load_o));

  // R2
  undiv_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (up == 2'd3 && sel_q == 2'd0 && $past(sel_q) == 2'd0 && $past(sel_q, 2) == 2'd0)
      |-> (pix_o != $past(pix_o)));

  // R3
  test_level_chk: assert property (@(posedge clk) disable iff (rst)
    (up >= 2'd2 && $past(sel_q) == 2'd3)
      |-> (pix_o == $past(aux_i) && load_o == $past(tst_load_i)));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt < ratio);

  // R5
  edge_align_chk: assert property (@(posedge clk) disable iff (rst)
    (up == 2'd3 && $past(sel_q) != 2'd3 && $past(sel_q, 2) != 2'd3 &&
     !$past(sup_i) && !$past(sup_i, 2) && load_o != $past(load_o))
      |-> (pix_o != $past(pix_o)));

  // R6
  code_take_chk: assert property (@(posedge clk) disable iff (rst)
    (up >= 2'd1 && code != $past(code)) |-> (ld_q && !$past(ld_q)));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph != '0) |-> (sel_q == $past(sel_q)));

  // R8
  suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (up >= 2'd2 && $past(sel_q) != 2'd3 && $past(sup_i)) |-> !load_o);

endmodule

bind postscale_loaddiv postscale_loaddiv_chk #(.PH_W(PH_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .sel_q(sel_q_w), .ph(ph_w), .pix_o(pix_o),
  .load_o(load_o), .aux_i(aux_i), .sup_i(sup_i), .tst_load_i(tst_load_i),
  .ld_q(ld_q_w), .cnt(cnt_w), .ratio(ratio_w), .code(code_w)
);

// File: tb/postscale_loaddiv_bench.sv
module postscale_loaddiv_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_i = 2'd0;
  logic [2:0] mod_i = 3'd1;
  logic       aux_i = 1'b0;
  logic       sup_i = 1'b0;
  logic       tst_load_i = 1'b0;
  logic       pix_o, load_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  postscale_loaddiv u_postscale_loaddiv (
    .clk(clk), .rst(rst), .sel_i(sel_i), .mod_i(mod_i), .aux_i(aux_i),
    .sup_i(sup_i), .tst_load_i(tst_load_i), .pix_o(pix_o), .load_o(load_o)
  );

  function automatic int ratio_exp(input int code);
    case (code)
      0: return 3;
      1: return 4;
      2: return 5;
      3: return 6;
      4: return 8;
      5: return 10;
      default: return 4;
    endcase
  endfunction

  function automatic int half_exp(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // behavioural reference: timebase, latched selection, edge counter, load level
  int  m_ph, m_sel, m_cnt, m_code;
  bit  m_pl, m_ld, m_pix, m_load, m_valid;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_sel = 0; m_cnt = 0; m_code = 1;
      m_pl = 0; m_ld = 0; m_pix = 0; m_load = 0; m_valid = 1;
    end else begin
      bit lvl, tk, ldn;
      int r;
      if (m_sel == 3) lvl = m_pl;
      else lvl = ((m_ph >> m_sel) & 1) != 0;
      tk = (lvl != m_pl);
      r = ratio_exp(m_code);
      ldn = m_ld;
      if (tk) begin
        if (m_cnt == r - 1) begin
          m_cnt = 0;
          ldn = !m_ld;
          if (!m_ld) m_code = int'(mod_i);
        end else m_cnt = m_cnt + 1;
      end
      m_pix  = (m_sel == 3) ? aux_i : lvl;
      m_load = (m_sel == 3) ? tst_load_i : (sup_i ? 1'b0 : ldn);
      m_ld = ldn;
      m_pl = lvl;
      if (m_ph == 7) m_sel = int'(sel_i);
      m_ph = (m_ph + 1) % 8;
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      check(pix_o == m_pix, "R1 R2 R7 model pix_o", int'(pix_o), int'(m_pix));
      check(load_o == m_load, "R4 R6 R8 model load_o", int'(load_o), int'(m_load));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // measure one high phase and the following low phase of load_o, in clk cycles
  task automatic meas_load(output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (load_o != 1'b0 && g < 500) begin @(negedge clk); g++; end
    while (load_o != 1'b1 && g < 1000) begin @(negedge clk); g++; end
    while (load_o == 1'b1 && hi < 500) begin hi++; @(negedge clk); end
    while (load_o == 1'b0 && lo < 500) begin lo++; @(negedge clk); end
  endtask

  task automatic meas_pix(output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (pix_o != 1'b0 && g < 50) begin @(negedge clk); g++; end
    while (pix_o != 1'b1 && g < 100) begin @(negedge clk); g++; end
    while (pix_o == 1'b1 && hi < 50) begin hi++; @(negedge clk); end
    while (pix_o == 1'b0 && lo < 50) begin lo++; @(negedge clk); end
  endtask

  initial begin
    int hi, lo, h2, l2;
    wait_cyc(3);
    // R1: outputs low while reset is held
    check(pix_o == 1'b0, "R1 pix_o in reset", int'(pix_o), 0);
    check(load_o == 1'b0, "R1 load_o in reset", int'(load_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(load_o == 1'b0, "R1 load_o first cycle", int'(load_o), 0);
    // R1: default ratio 4 at the undivided rate
    meas_load(hi, lo);
    check(hi == 4, "R1 default high phase", hi, 4);
    check(lo == 4, "R1 default low phase", lo, 4);

    // R4 R5: every ratio code at the undivided rate
    for (int c = 0; c < 8; c++) begin
      mod_i = 3'(c);
      wait_cyc(50);
      meas_load(hi, lo);
      check(hi == ratio_exp(c), "R4 R5 high phase", hi, ratio_exp(c));
      check(lo == ratio_exp(c), "R4 R5 low phase", lo, ratio_exp(c));
    end

    // R2: pixel period per select code, with load phases scaled by it
    for (int s = 0; s < 3; s++) begin
      sel_i = 2'(s);
      mod_i = (s == 2) ? 3'd2 : 3'd0;
      wait_cyc(120);
      meas_pix(hi, lo);
      check(hi == half_exp(s), "R2 pix high", hi, half_exp(s));
      check(lo == half_exp(s), "R2 pix low", lo, half_exp(s));
      meas_load(h2, l2);
      check(h2 == half_exp(s) * ratio_exp(int'(mod_i)), "R5 scaled high", h2,
            half_exp(s) * ratio_exp(int'(mod_i)));
      check(l2 == half_exp(s) * ratio_exp(int'(mod_i)), "R5 scaled low", l2,
            half_exp(s) * ratio_exp(int'(mod_i)));
    end
    sel_i = 2'd0;
    mod_i = 3'd1;
    wait_cyc(40);

    // R3: test mode static levels
    sel_i = 2'd3; aux_i = 1'b1; tst_load_i = 1'b0;
    wait_cyc(12);
    check(pix_o == 1'b1, "R3 pix follows aux", int'(pix_o), 1);
    check(load_o == 1'b0, "R3 load follows test bit", int'(load_o), 0);
    aux_i = 1'b0; tst_load_i = 1'b1;
    @(negedge clk);
    check(pix_o == 1'b0, "R3 pix one cycle later", int'(pix_o), 0);
    check(load_o == 1'b1, "R3 load one cycle later", int'(load_o), 1);
    tst_load_i = 1'b0;
    sel_i = 2'd0;
    wait_cyc(40);

    // R8: suppression holds load low, divider keeps running
    sup_i = 1'b1;
    @(negedge clk);
    hi = 0;
    for (int i = 0; i < 24; i++) begin
      if (load_o) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R8 load held low", hi, 0);
    sup_i = 1'b0;
    meas_load(hi, lo);
    check(hi == 4 && lo == 4, "R8 resumes ratio 4", hi, 4);

    // R6: ratio change during a high phase waits for the next high phase
    mod_i = 3'd5;
    wait_cyc(60);
    while (load_o != 1'b0) @(negedge clk);
    while (load_o != 1'b1) @(negedge clk);
    mod_i = 3'd0;
    hi = 0;
    while (load_o == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (load_o == 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    check(hi == 10, "R6 current high keeps old ratio", hi, 10);
    check(lo == 10, "R6 current low keeps old ratio", lo, 10);
    h2 = 0;
    while (load_o == 1'b1 && h2 < 100) begin h2++; @(negedge clk); end
    check(h2 == 3, "R6 next high uses new ratio", h2, 3);

    // R7: selection change lands on an 8-cycle boundary (model compares each cycle)
    wait_cyc(3);
    sel_i = 2'd1;
    wait_cyc(30);
    meas_pix(hi, lo);
    check(hi == 2, "R7 new selection active", hi, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule